// File: doc/BRIEF.md
# Mains-Clocked Calendar Timekeeper

This block keeps wall-clock time and a calendar using the utility mains as its time base. A digitized pulse, one rising edge per mains cycle, is synchronized and counted. Five cycles make a tenth of a second when the block is configured for a 50 Hz supply, and six cycles make one for a 60 Hz supply. From the tenths upward, a chain of BCD counters tracks seconds, minutes, hours, day of week, date, month and a two-digit year. Short months and leap years are handled in hardware.

Software reaches the block through a plain register write port and a combinational read port. A write to any time or calendar field restarts the sub-second phase, so loaded time begins on a clean tenth boundary. A control register selects 12-hour or 24-hour presentation of the hour and holds a power-fail flag. After reset, which stands for a total loss of supply, the flag is set and the clock stays halted. It starts only when software writes one of the time or calendar fields.

Top module: `mains_rtc`

## Requirements
- R1: After reset the fields read tenths 0, seconds 00, minutes 00, hours 00, day of week 0, date 01, month 01 and year 00. All values are BCD. The field addresses are 0 tenths, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year, and address 8 is control.
- R2: After reset no mains edge advances any field until a write to address 0 to 7. A write to control does not start the clock.
- R3: With `hz60_i` low the tenths field advances once per 5 mains rising edges. With `hz60_i` high it advances once per 6.
- R4: Tenths wrap 9 to 0 and carry into seconds. Seconds and minutes wrap 59 to 00 and carry onward. Hours wrap 23 to 00 and carry into both the day of week and the date. Every digit stays BCD.
- R5: Day of week counts 0 to 6 and wraps to 0 on each day carry, whatever the date is doing.
- R6: The date wraps to 01 and carries into the month after the last day of the month: 30 for April, June, September and November, 31 for the other long months, and 28 for February in a non-leap year.
- R7: In a year divisible by four, February runs to 29. After December 31 of year 99 the calendar becomes January 01 of year 00.
- R8: Control bit 0 set selects 12-hour format. The hour then reads and writes as bit 7 = PM and bits 4:0 = BCD 01 to 12, with midnight shown as 12 AM and noon as 12 PM.
- R9: Control bit 7 reads the power-fail flag, which is 1 after reset. Writing control with bit 7 = 0 clears the flag, and writing it with bit 7 = 1 leaves the flag unchanged.
- R10: A write to any field at address 0 to 7 clears the cycle prescaler. It also sets tenths to 0, unless tenths itself is the field written.
- R11: A field write in the same cycle as a tenth tick cancels that tick. The written value stands and no carry leaves the tenths field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power loss) |
| mains_i | input | 1 | Digitized mains-cycle pulse, asynchronous |
| hz60_i | input | 1 | 1: 60 Hz supply, 0: 50 Hz supply |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |

## Verification
Two functions can collide: a software field write and a tenth tick arriving on the same clock edge. The bench aligns the synchronized mains edge with a write strobe. It sets tenths to 9 and the prescaler to its last count, then writes the minutes exactly on the counting edge. The collision is judged correct when the minutes hold the written value, the seconds do not advance, tenths read 0, and the next tick needs a full prescale period.

// File: rtl/mains_rtc_pkg.sv
package mains_rtc_pkg;
  localparam int unsigned NUM_FIELDS = 8;
  localparam logic [3:0] A_TENTH = 4'd0;
  localparam logic [3:0] A_SEC   = 4'd1;
  localparam logic [3:0] A_MIN   = 4'd2;
  localparam logic [3:0] A_HOUR  = 4'd3;
  localparam logic [3:0] A_DOW   = 4'd4;
  localparam logic [3:0] A_DATE  = 4'd5;
  localparam logic [3:0] A_MONTH = 4'd6;
  localparam logic [3:0] A_YEAR  = 4'd7;
  localparam logic [3:0] A_CTRL  = 4'd8;

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] d);
    return 7'(d[7:4]) * 7'd10 + 7'(d[3:0]);
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [6:0] b);
    return {4'(b / 7'd10), 4'(b % 7'd10)};
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] d);
    return (d[3:0] == 4'd9) ? {d[7:4] + 4'd1, 4'd0} : {d[7:4], d[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/mains_rtc_presc.sv
module mains_rtc_presc #(
  parameter int unsigned DIV_50      = 5,
  parameter int unsigned DIV_60      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mains_i,
  input  logic sel60_i,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned DMAX = (DIV_50 > DIV_60) ? DIV_50 : DIV_60;
  localparam int unsigned CW   = $clog2(DMAX + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CW-1:0]          cnt_q;
  logic [CW-1:0]          last_cnt;
  logic                   rise, at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], mains_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise     = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign last_cnt = sel60_i ? CW'(DIV_60 - 1) : CW'(DIV_50 - 1);
  // >= so a mid-count switch from 60 to 50 Hz cannot skip the terminal count
  assign at_last  = (cnt_q >= last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (run_i && rise)  cnt_q <= at_last ? '0 : cnt_q + CW'(1);
  end

  assign tick_o = run_i & rise & at_last & ~clr_i;
endmodule

// File: rtl/mains_rtc_field.sv
module mains_rtc_field
  import mains_rtc_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic [7:0] min_i,
  input  logic [7:0] max_i,
  output logic [7:0] q_o,
  output logic       carry_o
);
  logic [7:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= RST_VAL;
    else if (load_i) q_q <= load_val_i;
    else if (inc_i)  q_q <= (q_q == max_i) ? min_i : bcd_inc(q_q);
  end

  assign q_o     = q_q;
  assign carry_o = inc_i & ~load_i & (q_q == max_i);
endmodule

// File: rtl/mains_rtc_mlen.sv
module mains_rtc_mlen
  import mains_rtc_pkg::*;
(
  input  logic [7:0] month_i,
  input  logic [7:0] year_i,
  output logic [7:0] last_day_o
);
  logic [6:0] yb;
  assign yb = bcd_to_bin(year_i);

  always_comb begin
    unique case (month_i)
      8'h02:                      last_day_o = (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/mains_rtc.sv
module mains_rtc
  import mains_rtc_pkg::*;
#(
  parameter int unsigned DIV_50      = 5,
  parameter int unsigned DIV_60      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mains_i,
  input  logic       hz60_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [3:0] rd_addr_i,
  output logic [7:0] rd_data_o
);
  logic                  run_q, fail_q, mode12_q;
  logic                  clk_wr, tick;
  logic [NUM_FIELDS-1:0] fld_we, fld_inc, fld_ld, fld_cy;
  logic [7:0]            fld_q   [NUM_FIELDS];
  logic [7:0]            fld_min [NUM_FIELDS];
  logic [7:0]            fld_max [NUM_FIELDS];
  logic [7:0]            fld_d   [NUM_FIELDS];
  logic [7:0]            last_day;
  logic [6:0]            wr_h12, wr_h24, rd_hb, rd_hm, rd_h12;
  logic [7:0]            rd_h12_bcd, hour_view;
  logic                  rd_pm;

  assign clk_wr = wr_en_i && (wr_addr_i < A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      fail_q   <= 1'b1;
      mode12_q <= 1'b0;
    end else begin
      if (clk_wr) run_q <= 1'b1;
      if (wr_en_i && wr_addr_i == A_CTRL) begin
        mode12_q <= wr_data_i[0];
        if (!wr_data_i[7]) fail_q <= 1'b0;
      end
    end
  end

  mains_rtc_presc #(
    .DIV_50(DIV_50), .DIV_60(DIV_60), .SYNC_STAGES(SYNC_STAGES)
  ) presc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mains_i(mains_i), .sel60_i(hz60_i),
    .run_i(run_q), .clr_i(clk_wr), .tick_o(tick)
  );

  mains_rtc_mlen mlen_i (
    .month_i(fld_q[A_MONTH]), .year_i(fld_q[A_YEAR]), .last_day_o(last_day)
  );

  // 12-hour write translation to internal 24-hour BCD
  assign wr_h12 = bcd_to_bin({3'b000, wr_data_i[4:0]});
  assign wr_h24 = ((wr_h12 == 7'd12) ? 7'd0 : wr_h12) + (wr_data_i[7] ? 7'd12 : 7'd0);

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) begin
      fld_we[i]  = wr_en_i && (wr_addr_i == 4'(i));
      fld_min[i] = 8'h00;
      fld_d[i]   = wr_data_i;
    end
    fld_min[A_DATE]  = 8'h01;
    fld_min[A_MONTH] = 8'h01;
    fld_max[A_TENTH] = 8'h09;
    fld_max[A_SEC]   = 8'h59;
    fld_max[A_MIN]   = 8'h59;
    fld_max[A_HOUR]  = 8'h23;
    fld_max[A_DOW]   = 8'h06;
    fld_max[A_DATE]  = last_day;
    fld_max[A_MONTH] = 8'h12;
    fld_max[A_YEAR]  = 8'h99;
    fld_d[A_TENTH]   = fld_we[A_TENTH] ? wr_data_i : 8'h00;
    fld_d[A_HOUR]    = mode12_q ? bin_to_bcd(wr_h24) : wr_data_i;
    fld_ld           = fld_we;
    fld_ld[A_TENTH]  = clk_wr;
    fld_inc[A_TENTH] = tick;
    fld_inc[A_SEC]   = fld_cy[A_TENTH];
    fld_inc[A_MIN]   = fld_cy[A_SEC];
    fld_inc[A_HOUR]  = fld_cy[A_MIN];
    fld_inc[A_DOW]   = fld_cy[A_HOUR];
    fld_inc[A_DATE]  = fld_cy[A_HOUR];
    fld_inc[A_MONTH] = fld_cy[A_DATE];
    fld_inc[A_YEAR]  = fld_cy[A_MONTH];
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam logic [7:0] RV = (g == A_DATE || g == A_MONTH) ? 8'h01 : 8'h00;
    mains_rtc_field #(.RST_VAL(RV)) fld_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(fld_inc[g]), .load_i(fld_ld[g]),
      .load_val_i(fld_d[g]), .min_i(fld_min[g]), .max_i(fld_max[g]),
      .q_o(fld_q[g]), .carry_o(fld_cy[g])
    );
  end

  // 12-hour read view
  assign rd_hb      = bcd_to_bin(fld_q[A_HOUR]);
  assign rd_pm      = (rd_hb >= 7'd12);
  assign rd_hm      = rd_pm ? rd_hb - 7'd12 : rd_hb;
  assign rd_h12     = (rd_hm == 7'd0) ? 7'd12 : rd_hm;
  assign rd_h12_bcd = bin_to_bcd(rd_h12);
  assign hour_view  = mode12_q ? {rd_pm, 2'b00, rd_h12_bcd[4:0]} : fld_q[A_HOUR];

  always_comb begin
    if (rd_addr_i == A_CTRL)      rd_data_o = {fail_q, 6'b0, mode12_q};
    else if (rd_addr_i == A_HOUR) rd_data_o = hour_view;
    else if (rd_addr_i < A_CTRL)  rd_data_o = fld_q[rd_addr_i[2:0]];
    else                          rd_data_o = 8'h00;
  end
endmodule

// File: rtl/mains_rtc_chk.sv
module mains_rtc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic       tick_i,
  input logic       clk_wr_i,
  input logic [3:0] wr_addr_i,
  input logic [7:0] tenth_i,
  input logic [7:0] dow_i,
  input logic [7:0] date_i,
  input logic [7:0] last_day_i,
  input logic       day_inc_i,
  input logic       fail_i
);
  assert_halt_no_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_i);
  assert_run_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> run_i);
  assert_tenth_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && tenth_i == 8'h09) |=> tenth_i == 8'h00);
  assert_dow_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_inc_i && dow_i == 8'h06) |=> dow_i == 8'h00);
  assert_month_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_inc_i && date_i == last_day_i) |=> date_i == 8'h01);
  assert_fail_no_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(fail_i));
  assert_wr_zero_tenth_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_wr_i && wr_addr_i != 4'd0) |=> tenth_i == 8'h00);
  assert_wr_drops_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_wr_i |-> !tick_i);
endmodule

bind mains_rtc mains_rtc_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .tick_i(tick),
  .clk_wr_i(clk_wr), .wr_addr_i(wr_addr_i), .tenth_i(fld_q[0]),
  .dow_i(fld_q[4]), .date_i(fld_q[5]), .last_day_i(last_day),
  .day_inc_i(fld_cy[3]), .fail_i(fail_q)
);

// File: tb/mains_rtc_tb_top.sv
`timescale 1ns/1ps
module mains_rtc_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mains_i = 1'b0;
  logic       hz60_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [3:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  mains_rtc dut_i (.*);

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    rd_addr_i = a;
    #0.5;
    v = rd_data_o;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); mains_i = 1'b1;
      repeat (2) @(negedge clk_i);
      mains_i = 1'b0;
      repeat (2) @(negedge clk_i);
    end
  endtask

  task automatic end_of_day(input int yr, input int mo, input int dt, input int dw, input int hr);
    wr(4'd7, to_bcd(yr)); wr(4'd6, to_bcd(mo)); wr(4'd5, to_bcd(dt));
    wr(4'd4, to_bcd(dw)); wr(4'd3, to_bcd(hr)); wr(4'd2, 8'h59);
    wr(4'd1, 8'h59); wr(4'd0, 8'h09);
    pulse(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), v);
      chk("R1 reset field", v, (a == 5 || a == 6) ? 8'h01 : 8'h00);
    end
    rd(4'd8, v); chk("R9 fail set after reset", v, 8'h80);

    // R2 halted until a field write; control write keeps it halted
    pulse(12);
    rd(4'd0, v); chk("R2 halted tenths", v, 8'h00);
    wr(4'd8, 8'h80);
    pulse(12);
    rd(4'd0, v); chk("R2 control write does not start", v, 8'h00);
    rd(4'd8, v); chk("R9 write 1 leaves flag", v, 8'h80);
    wr(4'd8, 8'h00);
    rd(4'd8, v); chk("R9 write 0 clears flag", v, 8'h00);

    // R3 50 Hz and 60 Hz division
    wr(4'd0, 8'h00);
    pulse(4); rd(4'd0, v); chk("R3 50Hz before 5th edge", v, 8'h00);
    pulse(1); rd(4'd0, v); chk("R3 50Hz at 5th edge", v, 8'h01);
    hz60_i = 1'b1;
    wr(4'd0, 8'h00);
    pulse(5); rd(4'd0, v); chk("R3 60Hz before 6th edge", v, 8'h00);
    pulse(1); rd(4'd0, v); chk("R3 60Hz at 6th edge", v, 8'h01);
    hz60_i = 1'b0;

    // R10 field write clears prescaler and tenths
    wr(4'd0, 8'h05);
    rd(4'd0, v); chk("R10 tenths written directly", v, 8'h05);
    pulse(3);
    wr(4'd1, 8'h10);
    rd(4'd0, v); chk("R10 tenths zeroed by seconds write", v, 8'h00);
    pulse(4); rd(4'd0, v); chk("R10 prescaler restarted", v, 8'h00);
    pulse(1); rd(4'd0, v); chk("R10 first tick after restart", v, 8'h01);
    rd(4'd1, v); chk("R10 seconds kept", v, 8'h10);

    // R4 sweep of 700 tenths through the tenths/seconds/minutes cascade
    wr(4'd2, 8'h00); wr(4'd1, 8'h00); wr(4'd0, 8'h00);
    for (int k = 1; k <= 700; k++) begin
      pulse(5);
      rd(4'd0, v); chk("R4 sweep tenths", v, to_bcd(k % 10));
      rd(4'd1, v); chk("R4 sweep seconds", v, to_bcd((k / 10) % 60));
      rd(4'd2, v); chk("R4 sweep minutes", v, to_bcd(k / 600));
    end
    end_of_day(50, 3, 10, 2, 9);
    rd(4'd3, v); chk("R4 hour 09 to 10", v, 8'h10);

    // R5 day of week wraps independently of date
    for (int d = 0; d < 7; d++) begin
      end_of_day(23, 5, 10, d, 23);
      rd(4'd4, v); chk("R5 dow step", v, to_bcd((d + 1) % 7));
      rd(4'd5, v); chk("R5 date step", v, 8'h11);
      rd(4'd3, v); chk("R4 hour 23 to 00", v, 8'h00);
    end

    // R6/R7 month lengths in a plain and a leap year
    for (int y = 23; y <= 24; y++) begin
      for (int m = 1; m <= 12; m++) begin
        end_of_day(y, m, mdays(m, y) - 1, 0, 23);
        rd(4'd5, v);
        chk((m == 2) ? "R7 feb penultimate" : "R6 penultimate day", v, to_bcd(mdays(m, y)));
        end_of_day(y, m, mdays(m, y), 0, 23);
        rd(4'd5, v); chk("R6 date wraps", v, 8'h01);
        rd(4'd6, v); chk("R6 month step", v, to_bcd(m % 12 + 1));
        rd(4'd7, v); chk("R7 year step", v, to_bcd((m == 12) ? y + 1 : y));
      end
    end
    end_of_day(99, 12, 31, 6, 23);
    rd(4'd7, v); chk("R7 year 99 wraps", v, 8'h00);
    rd(4'd6, v); chk("R7 month after dec", v, 8'h01);
    rd(4'd5, v); chk("R7 date after dec", v, 8'h01);
    rd(4'd4, v); chk("R5 dow wrap at year end", v, 8'h00);

    // R8 12-hour view and write translation for every hour
    for (int h = 0; h < 24; h++) begin
      e = {(h >= 12) ? 1'b1 : 1'b0, 2'b00, 5'(to_bcd((h % 12 == 0) ? 12 : h % 12))};
      wr(4'd8, 8'h00); wr(4'd3, to_bcd(h));
      wr(4'd8, 8'h01);
      rd(4'd3, v); chk("R8 12h read", v, e);
      wr(4'd3, 8'h00); wr(4'd3, e);
      wr(4'd8, 8'h00);
      rd(4'd3, v); chk("R8 12h write", v, to_bcd(h));
    end

    // R11 write coinciding with the tenth tick
    wr(4'd2, 8'h00); wr(4'd1, 8'h00); wr(4'd0, 8'h09);
    pulse(4);
    @(negedge clk_i); mains_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 4'd2; wr_data_i = 8'h07; mains_i = 1'b0;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rd(4'd2, v); chk("R11 written minutes stand", v, 8'h07);
    rd(4'd1, v); chk("R11 no carry to seconds", v, 8'h00);
    rd(4'd0, v); chk("R11 tenths zero", v, 8'h00);
    pulse(4); rd(4'd0, v); chk("R11 full period after collision", v, 8'h00);
    pulse(1); rd(4'd0, v); chk("R11 tick after full period", v, 8'h01);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule